// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block sequences power-down for a small microcontroller core. The instruction decoder raises a one-cycle sleep request when it retires a sleep instruction. The controller then switches the oscillator enable off, pulses a watchdog clear and updates two status bits. The first bit is power-down (`pd_bit`). The second is time-out (`to_bit`). If an enabled interrupt is already pending when the request arrives, the sleep is retired as a no-op, and the watchdog and both status bits keep their values.

While asleep, the controller watches the interrupt vectors and the watchdog time-out pulse. Interrupt source i is pending when both `irq_en[i]` and `irq_flag[i]` are 1. Any pending source, or a time-out, starts a one-cycle WAKE state. The global interrupt enable plays no part in that decision. During WAKE, the oscillator is back on, the watchdog is cleared again, and the core is told what to do next. It either resumes at the next instruction, or runs that instruction and then branches to the interrupt vector `vector_addr` (0x0004 by default). The choice depends on the global interrupt enable.

The active-low external reset is asynchronous and returns the controller to RUN. A watchdog time-out while the core is awake does not wake anything. It raises a reset request instead.

Top module: `slp_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the outputs are as follows: `osc_en`=1, `pd_bit`=1, `to_bit`=1, `rst_cause`=2'b01 (external), and `wdt_clr`, `resume_next`, `vector_take` and `reset_req` are all 0.
- R2: A `sleep_req` in RUN, with no pending source and no time-out, takes effect in the next cycle. In that cycle `osc_en`=0, `wdt_clr` is high for exactly one cycle, `pd_bit`=0 and `to_bit`=1.
- R3: A `sleep_req` in RUN while a source is pending completes as a no-op. `osc_en` stays 1, `wdt_clr` stays 0, and `pd_bit` and `to_bit` are unchanged.
- R4: Asleep, a pending source wakes the block whatever the value of `gie`. In the next cycle `osc_en`=1 and `wdt_clr`=1. One cycle later the block is back in RUN, with the wake pulses low.
- R5: The wake cycle pulses exactly one of two outputs. It pulses `resume_next` when `gie`=0, and `vector_take` when `gie`=1. `vector_addr` equals 0x0004.
- R6: Asleep, a `wdt_timeout` wakes the block without a reset. It clears `to_bit` and pulses `wdt_clr` and the resume or vector output. `pd_bit` stays 0.
- R7: A `wdt_timeout` in RUN or WAKE pulses `reset_req` for one cycle in the next cycle. It also clears `to_bit` and sets `rst_cause` to 2'b10 (watchdog).
- R8: Asleep, the following do not wake the block: a flag whose enable is 0, an enable whose flag is 0, or a repeated `sleep_req`. `osc_en` stays 0 and no pulse appears.
- R9: A source that becomes pending in the cycle after a successful sleep entry does not undo that entry. The watchdog clear and the status updates of R2 stand, and the block wakes in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| sleep_req | input | 1 | One-cycle pulse from the decoder on a sleep instruction |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| irq_flag | input | N_IRQ | Per-source interrupt flags |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| osc_en | output | 1 | Oscillator driver enable |
| wdt_clr | output | 1 | Watchdog clear pulse |
| resume_next | output | 1 | Wake pulse: continue at the next instruction |
| vector_take | output | 1 | Wake pulse: run the next instruction, then branch to the vector |
| vector_addr | output | ADDR_W | Interrupt vector address |
| reset_req | output | 1 | Reset request from a watchdog time-out while awake |
| rst_cause | output | 2 | Last reset cause: 01 external, 10 watchdog |
| pd_bit | output | 1 | Power-down status bit |
| to_bit | output | 1 | Time-out status bit |

## Verification
The bench first retires a sleep request while an enabled flag is already set. A design that ignored the pending source would clear the watchdog and drop `pd_bit` on that no-op. It then sets flags and enables on different sources while asleep. A controller that ORed flags without their enables would wake on a disabled source. Wake-ups are forced with `gie` both clear and set, and a design that gated wake on `gie` would stay asleep. Watchdog time-outs are applied asleep and awake, to catch a design that resets on a sleeping time-out or wakes on a waking one. An interrupt is raised one cycle after entry, to catch a design that rolls back the entry status.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } slp_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_EXT  = 2'b01,
    CAUSE_WDT  = 2'b10
  } rst_cause_e;
endpackage

// File: rtl/slp_irq_pending.sv
module slp_irq_pending #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_IRQ-1:0] irq_flag,
  output logic             pending
);
  logic [N_IRQ-1:0] armed;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    assign armed[i] = irq_en[i] & irq_flag[i];
  end

  assign pending = |armed;
endmodule

// File: rtl/slp_seq_fsm.sv
module slp_seq_fsm
  import slp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       pending,
  input  logic       gie,
  input  logic       wdt_timeout,
  output slp_state_e state_q,
  output logic       enter_sleep,
  output logic       wdt_clr,
  output logic       resume_next,
  output logic       vector_take,
  output logic       reset_req,
  output logic [1:0] rst_cause
);
  slp_state_e state_d;
  logic       awake;
  logic       wake_evt;

  assign awake       = (state_q != ST_SLEEP);
  assign wake_evt    = (state_q == ST_SLEEP) && (pending || wdt_timeout);
  assign enter_sleep = (state_q == ST_RUN) && sleep_req && !pending && !wdt_timeout;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:   if (enter_sleep) state_d = ST_SLEEP;
      ST_SLEEP: if (wake_evt)    state_d = ST_WAKE;
      ST_WAKE:                   state_d = ST_RUN;
      default:                   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      wdt_clr     <= 1'b0;
      resume_next <= 1'b0;
      vector_take <= 1'b0;
      reset_req   <= 1'b0;
      rst_cause   <= CAUSE_EXT;
    end else begin
      state_q     <= state_d;
      wdt_clr     <= enter_sleep || wake_evt;
      resume_next <= wake_evt && !gie;
      vector_take <= wake_evt && gie;
      reset_req   <= awake && wdt_timeout;
      if (awake && wdt_timeout) rst_cause <= CAUSE_WDT;
    end
  end
endmodule

// File: rtl/slp_status_bits.sv
module slp_status_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_sleep,
  input  logic wdt_timeout,
  output logic pd_bit,
  output logic to_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_bit <= 1'b1;
      to_bit <= 1'b1;
    end else begin
      if (enter_sleep) pd_bit <= 1'b0;
      if (wdt_timeout)      to_bit <= 1'b0;
      else if (enter_sleep) to_bit <= 1'b1;
    end
  end
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
  import slp_pkg::*;
#(
  parameter int N_IRQ       = 8,
  parameter int ADDR_W      = 13,
  parameter int VECTOR_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic [N_IRQ-1:0]  irq_en,
  input  logic [N_IRQ-1:0]  irq_flag,
  input  logic              gie,
  input  logic              wdt_timeout,
  output logic              osc_en,
  output logic              wdt_clr,
  output logic              resume_next,
  output logic              vector_take,
  output logic [ADDR_W-1:0] vector_addr,
  output logic              reset_req,
  output logic [1:0]        rst_cause,
  output logic              pd_bit,
  output logic              to_bit
);
  localparam logic [ADDR_W-1:0] VEC = ADDR_W'(VECTOR_ADDR);

  logic       pending;
  logic       enter_sleep;
  slp_state_e state_q;

  slp_irq_pending #(.N_IRQ(N_IRQ)) u_pend (
    .irq_en   (irq_en),
    .irq_flag (irq_flag),
    .pending  (pending)
  );

  slp_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .pending     (pending),
    .gie         (gie),
    .wdt_timeout (wdt_timeout),
    .state_q     (state_q),
    .enter_sleep (enter_sleep),
    .wdt_clr     (wdt_clr),
    .resume_next (resume_next),
    .vector_take (vector_take),
    .reset_req   (reset_req),
    .rst_cause   (rst_cause)
  );

  slp_status_bits u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_sleep (enter_sleep),
    .wdt_timeout (wdt_timeout),
    .pd_bit      (pd_bit),
    .to_bit      (to_bit)
  );

  assign osc_en      = (state_q != ST_SLEEP);
  assign vector_addr = VEC;
endmodule

// File: rtl/slp_wake_ctrl_chk.sv
module slp_wake_ctrl_chk
  import slp_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_req,
  input logic [N_IRQ-1:0] irq_en,
  input logic [N_IRQ-1:0] irq_flag,
  input logic             wdt_timeout,
  input slp_state_e       state_q,
  input logic             osc_en,
  input logic             wdt_clr,
  input logic             resume_next,
  input logic             vector_take,
  input logic             reset_req,
  input logic             pd_bit,
  input logic             to_bit
);
  logic src_live;
  assign src_live = |(irq_en & irq_flag);

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_req && !src_live && !wdt_timeout) |=> (!osc_en && wdt_clr && !pd_bit && to_bit)); // R2

  AST_NOOP_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_req && src_live && !wdt_timeout) |=> (osc_en && !wdt_clr && $stable(pd_bit) && $stable(to_bit))); // R3

  AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && src_live) |=> (osc_en && wdt_clr && (resume_next != vector_take))); // R4

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_next || vector_take) |=> !(resume_next || vector_take)); // R5

  AST_WDT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && wdt_timeout) |=> (!to_bit && !reset_req && osc_en)); // R6

  AST_WDT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_SLEEP && wdt_timeout) |=> (reset_req && !to_bit)); // R7

  AST_NO_SPURIOUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && !src_live && !wdt_timeout) |=> (!osc_en && !wdt_clr)); // R8
endmodule

bind slp_wake_ctrl slp_wake_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_req   (sleep_req),
  .irq_en      (irq_en),
  .irq_flag    (irq_flag),
  .wdt_timeout (wdt_timeout),
  .state_q     (state_q),
  .osc_en      (osc_en),
  .wdt_clr     (wdt_clr),
  .resume_next (resume_next),
  .vector_take (vector_take),
  .reset_req   (reset_req),
  .pd_bit      (pd_bit),
  .to_bit      (to_bit)
);

// File: tb/slp_wake_ctrl_test.sv
module slp_wake_ctrl_test;
  localparam int N_IRQ  = 8;
  localparam int ADDR_W = 13;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sleep_req = 1'b0;
  logic [N_IRQ-1:0]  irq_en = '0;
  logic [N_IRQ-1:0]  irq_flag = '0;
  logic              gie = 1'b0;
  logic              wdt_timeout = 1'b0;
  logic              osc_en, wdt_clr, resume_next, vector_take, reset_req, pd_bit, to_bit;
  logic [ADDR_W-1:0] vector_addr;
  logic [1:0]        rst_cause;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // expected outputs {osc, clr, res, vec, rreq, pd, to} and requirement number
  typedef struct packed {
    logic [6:0] outs;
    int         req;
  } exp_t;
  exp_t sb_q[$];

  slp_wake_ctrl #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .irq_en(irq_en),
    .irq_flag(irq_flag), .gie(gie), .wdt_timeout(wdt_timeout), .osc_en(osc_en),
    .wdt_clr(wdt_clr), .resume_next(resume_next), .vector_take(vector_take),
    .vector_addr(vector_addr), .reset_req(reset_req), .rst_cause(rst_cause),
    .pd_bit(pd_bit), .to_bit(to_bit)
  );

  always #2 clk = ~clk;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic slp, input logic [N_IRQ-1:0] en, input logic [N_IRQ-1:0] fl,
                      input logic g, input logic wdt, input logic [6:0] outs, input int req);
    exp_t e;
    @(negedge clk);
    sleep_req = slp; irq_en = en; irq_flag = fl; gie = g; wdt_timeout = wdt;
    e.outs = outs;
    e.req  = req;
    sb_q.push_back(e);
  endtask

  // monitor: compare after each active edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.req, {25'd0, osc_en, wdt_clr, resume_next, vector_take, reset_req, pd_bit, to_bit},
            {25'd0, e.outs});
    end
  end

  // watchdog for the bench
  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while held and after release
    check(1, {31'd0, osc_en}, 32'd1);
    check(1, {30'd0, pd_bit, to_bit}, 32'd3);
    check(1, {30'd0, rst_cause}, 32'd1);
    check(1, {28'd0, wdt_clr, resume_next, vector_take, reset_req}, 32'd0);
    rst_n = 1'b1;
    step(0, 8'h00, 8'h00, 0, 0, 7'b1000011, 1);   // R1 idle after release
    // R3 no-op sleep with source 0 pending
    step(1, 8'h01, 8'h01, 0, 0, 7'b1000011, 3);
    step(0, 8'h01, 8'h00, 0, 0, 7'b1000011, 3);
    // R2 sleep entry: flags without enables do not count as pending
    step(1, 8'h00, 8'hFF, 0, 0, 7'b0100001, 2);
    // R8 mismatched enable/flag and repeated request while asleep
    step(0, 8'h0F, 8'hF0, 0, 0, 7'b0000001, 8);
    step(1, 8'hF0, 8'h0F, 1, 0, 7'b0000001, 8);
    // R4 R5 wake with gie clear -> resume
    step(0, 8'h10, 8'h10, 0, 0, 7'b1110001, 4);
    step(0, 8'h00, 8'h00, 0, 0, 7'b1000001, 4);
    // R5 wake with gie set -> vector
    step(1, 8'h00, 8'h00, 1, 0, 7'b0100001, 2);
    step(0, 8'h80, 8'h80, 1, 0, 7'b1101001, 5);
    step(0, 8'h00, 8'h00, 1, 0, 7'b1000001, 5);
    check(5, {19'd0, vector_addr}, 32'h4);
    // R9 interrupt one cycle after entry
    step(1, 8'h00, 8'h00, 0, 0, 7'b0100001, 9);
    step(0, 8'h02, 8'h02, 0, 0, 7'b1110001, 9);
    step(0, 8'h00, 8'h00, 0, 0, 7'b1000001, 9);
    // R6 watchdog wake from sleep
    step(1, 8'h00, 8'h00, 0, 0, 7'b0100001, 6);
    step(0, 8'h00, 8'h00, 0, 1, 7'b1110000, 6);
    step(0, 8'h00, 8'h00, 0, 0, 7'b1000000, 6);
    // R7 watchdog while awake -> reset request
    step(0, 8'h00, 8'h00, 0, 1, 7'b1000100, 7);
    step(0, 8'h00, 8'h00, 0, 0, 7'b1000000, 7);
    @(negedge clk);
    check(7, {30'd0, rst_cause}, 32'd2);
    // R2 re-entry sets to_bit again
    step(1, 8'h00, 8'h00, 0, 0, 7'b0100001, 2);
    step(0, 8'h00, 8'h00, 0, 0, 7'b0000001, 8);
    @(negedge clk);
    @(negedge clk);
    // R1 asynchronous reset while asleep
    rst_n = 1'b0;
    #1;
    check(1, {31'd0, osc_en}, 32'd1);
    check(1, {30'd0, pd_bit, to_bit}, 32'd3);
    check(1, {30'd0, rst_cause}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 8'h00, 8'h00, 0, 0, 7'b1000011, 1);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule